// File: doc/BRIEF.md
# Dual-Channel Register Reset Sequencer

This block owns the reset behaviour of a two-channel serial controller's register file. It watches the active-low read and write strobes, and it takes the otherwise illegal case of both strobes low together as a hardware reset. A write to the command register (index 9) can also ask for one of three software resets: channel A only, channel B only, or a full reset that has the same effect as the hardware one. After any trigger goes away, every reset stays active for a fixed number of peripheral-clock cycles. While reset is active the bus is shut out, and the reset values are loaded into each channel's registers.

Both strobes pass through two flip-flop stages into the peripheral-clock domain. A strobe overlap of a single cycle is filtered out, so a normal handoff from read to write cannot reset the chip. A write takes effect on the synchronised rising edge of the write strobe. The register contents come out directly on two 40-bit channel buses and a command-register output. There is also a gated read port for the status and command registers.

Top module: `sercom_rst_seq`

## Requirements
- R1: A hardware reset starts when the synchronised read and write strobes are both low on two consecutive clock cycles, and it lasts as long as they stay low. An overlap seen for only one cycle causes no reset and changes no register.
- R2: After a trigger disappears, all reset activity and access blocking continue for STRETCH (default 4) more cycles. After a hardware reset, `acc_en` is low at the 5th rising edge after the strobes are released and high again from the 6th.
- R3: While `acc_en` is low, writes are not stored and `rd_data` reads 0x00.
- R4: A write commits on the synchronised rising edge of `wr_n` while `rd_n` has been high for two synchronised cycles. The target is the channel picked by `ch_sel` (0 = A, 1 = B). Indices 0, 11, 14 and 15 are per-channel registers. Index 9 is the shared command register. Every other index has no effect. `rd_data` returns the status register of the selected channel for index 1 and the command register for index 9.
- R5: A hardware reset loads the command register with 1100_00 in bits 7:2 and keeps bits 1:0. Software resets never alter it, so a reset command leaves it holding the byte just written.
- R6: A full reset (hardware, or command bits 7:6 = 11) asserts both `rst_a` and `rst_b`. In each channel it loads reg0 = 0x00, reg11 = 0x08, reg14 = {kept 7:6, 110000} and reg15 = 0xF8. It loads the status register with 0000011 in bits 7:1 and keeps bit 0.
- R7: Command bits 7:6 = 10 reset channel A only and 01 reset channel B only. The chosen channel gets reg0 = 0x00, reg14 = {kept 7:6, 1000, kept 1:0}, reg15 = 0xF8 and the same status load as R6. Its reg11 is unchanged. Only that channel's reset output rises.
- R8: A channel reset leaves the other channel's registers untouched. Command bits 7:6 = 00 start no reset.
- R9: Each channel bus is packed as {reg0, reg11, reg14, reg15, status}, with reg0 in bits 39:32 and the status register in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | AW | Register index |
| din | input | 8 | Write data |
| ch_sel | input | 1 | Channel select, 0 = A, 1 = B |
| rst_a | output | 1 | Channel A reset active |
| rst_b | output | 1 | Channel B reset active |
| acc_en | output | 1 | Bus access accepted |
| rd_data | output | 8 | Read data, zero while blocked |
| cmd_reg | output | 8 | Command register contents |
| regs_a | output | 40 | Channel A register contents |
| regs_b | output | 40 | Channel B register contents |

## Verification
The bench drives a one-cycle strobe overlap. A design that skipped the filter would reset and wipe the registers written just before. It counts the exact edge on which access comes back after a hardware reset, so a counter that is one cycle short or long shows up as a wrong `acc_en` value. It also releases the read strobe one cycle before the write strobe, which produces a write edge inside the stretch window; a design that did not block the bus would store that byte. Reset commands are written with non-zero low bits, and kept bits are tracked per field. This catches a command register cleared by software resets, a channel reset that leaks into the other channel, and kept bits that were overwritten.

// File: rtl/sercom_rst_seq.sv
module sercom_rst_seq #(
  parameter int STRETCH = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          ch_sel,
  output logic          rst_a,
  output logic          rst_b,
  output logic          acc_en,
  output logic [7:0]    rd_data,
  output logic [7:0]    cmd_reg,
  output logic [39:0]   regs_a,
  output logic [39:0]   regs_b
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);
  localparam logic [AW-1:0] IX_CTL  = AW'(0);
  localparam logic [AW-1:0] IX_STAT = AW'(1);
  localparam logic [AW-1:0] IX_CMD  = AW'(9);
  localparam logic [AW-1:0] IX_MODE = AW'(11);
  localparam logic [AW-1:0] IX_AUX  = AW'(14);
  localparam logic [AW-1:0] IX_IEN  = AW'(15);

  logic [1:0] rd_sy, wr_sy;
  logic rd_q, wr_q, both_q, armed_q;
  logic [CW-1:0] cnt_h, cnt_f, cnt_a, cnt_b;
  logic [7:0] cmd_q;
  logic [7:0] r_ctl[2], r_mode[2], r_aux[2], r_ien[2], r_stat[2];

  wire rd_s     = rd_sy[1];
  wire wr_s     = wr_sy[1];
  wire both_low = ~rd_s & ~wr_s;
  wire hw_trig  = both_low & both_q;
  wire busy     = hw_trig | (|cnt_h) | (|cnt_f) | (|cnt_a) | (|cnt_b);
  wire commit   = ~busy & wr_s & ~wr_q & rd_s & rd_q;
  wire cmd_hit  = commit & (addr == IX_CMD);
  wire sw_full  = cmd_hit & (din[7:6] == 2'b11);
  wire sw_a     = cmd_hit & (din[7:6] == 2'b10);
  wire sw_b     = cmd_hit & (din[7:6] == 2'b01);
  wire trig_f   = hw_trig | sw_full;
  wire h_act    = hw_trig | (|cnt_h);
  wire f_act    = trig_f | (|cnt_f);
  wire a_act    = sw_a | (|cnt_a);
  wire b_act    = sw_b | (|cnt_b);
  wire [1:0] ch_act = {b_act, a_act};

  assign acc_en  = ~busy;
  assign rst_a   = f_act | a_act;
  assign rst_b   = f_act | b_act;
  assign cmd_reg = cmd_q;
  assign regs_a  = {r_ctl[0], r_mode[0], r_aux[0], r_ien[0], r_stat[0]};
  assign regs_b  = {r_ctl[1], r_mode[1], r_aux[1], r_ien[1], r_stat[1]};

  always_ff @(posedge clk) begin
    rd_sy  <= {rd_sy[0], rd_n};
    wr_sy  <= {wr_sy[0], wr_n};
    rd_q   <= rd_s;
    wr_q   <= wr_s;
    both_q <= both_low;
    if (hw_trig) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    cnt_h <= hw_trig ? LOAD : cnt_h - CW'(cnt_h != '0);
    cnt_f <= trig_f  ? LOAD : cnt_f - CW'(cnt_f != '0);
    cnt_a <= sw_a    ? LOAD : cnt_a - CW'(cnt_a != '0);
    cnt_b <= sw_b    ? LOAD : cnt_b - CW'(cnt_b != '0);
  end

  always_ff @(posedge clk) begin
    if (h_act) cmd_q <= {6'b110000, cmd_q[1:0]};
    else if (cmd_hit) cmd_q <= din;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (f_act) begin
        r_ctl[c]  <= 8'h00;
        r_mode[c] <= 8'h08;
        r_aux[c]  <= {r_aux[c][7:6], 6'b110000};
        r_ien[c]  <= 8'hF8;
        r_stat[c] <= {7'b0000011, r_stat[c][0]};
      end else if (ch_act[c]) begin
        r_ctl[c]  <= 8'h00;
        r_aux[c]  <= {r_aux[c][7:6], 4'b1000, r_aux[c][1:0]};
        r_ien[c]  <= 8'hF8;
        r_stat[c] <= {7'b0000011, r_stat[c][0]};
      end else if (commit && (ch_sel == (c == 1))) begin
        case (addr)
          IX_CTL:  r_ctl[c]  <= din;
          IX_MODE: r_mode[c] <= din;
          IX_AUX:  r_aux[c]  <= din;
          IX_IEN:  r_ien[c]  <= din;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (acc_en) begin
      if (addr == IX_STAT) rd_data = r_stat[ch_sel];
      else if (addr == IX_CMD) rd_data = cmd_q;
    end
  end

  p_stretch_r2: assert property (@(posedge clk) disable iff (!armed_q)
    $fell(hw_trig) |-> (rst_a && rst_b && !acc_en));

  p_blocked_r3: assert property (@(posedge clk) disable iff (!armed_q)
    (!acc_en && !h_act) |=> $stable(cmd_q));

  p_cmd_hw_r5: assert property (@(posedge clk) disable iff (!armed_q)
    h_act |=> (cmd_q[7:2] == 6'b110000));

  p_full_vals_r6: assert property (@(posedge clk) disable iff (!armed_q)
    f_act |=> (r_ctl[0] == 8'h00 && r_ctl[1] == 8'h00 && r_mode[0] == 8'h08 &&
               r_ien[1] == 8'hF8 && r_aux[0][5:0] == 6'b110000));

  p_chan_vals_r7: assert property (@(posedge clk) disable iff (!armed_q)
    (a_act && !f_act) |=> (r_aux[0][5:2] == 4'b1000 && r_ctl[0] == 8'h00));

  p_isolate_r8: assert property (@(posedge clk) disable iff (!armed_q)
    (b_act && !a_act && !f_act) |=> ($stable(r_ien[0]) && $stable(r_aux[0]) && $stable(r_ctl[0])));
endmodule

// File: tb/sim_sercom_rst_seq.sv
`timescale 1ns/1ps
module sim_sercom_rst_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rd_n = 1'b1, wr_n = 1'b1, ch_sel = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] din = 8'h00;
  logic rst_a, rst_b, acc_en;
  logic [7:0] rd_data, cmd_reg;
  logic [39:0] regs_a, regs_b;

  sercom_rst_seq u0 (.clk(clk), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .ch_sel(ch_sel), .rst_a(rst_a), .rst_b(rst_b), .acc_en(acc_en), .rd_data(rd_data),
    .cmd_reg(cmd_reg), .regs_a(regs_a), .regs_b(regs_b));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] e0[2], e11[2], e14[2], e15[2], es[2], e9;
  logic [7:0] m0[2], m11[2], m14[2], m15[2], ms[2], m9;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp, logic [7:0] msk);
    total++;
    if (((act ^ exp) & msk) != 8'h00) begin
      bad++;
      $display("FAIL %s act=%h exp=%h mask=%h", req, act, exp, msk);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    logic [39:0] v;
    for (int c = 0; c < 2; c++) begin
      v = (c == 0) ? regs_a : regs_b;
      chk({req, " reg0"},   v[39:32], e0[c],  m0[c]);
      chk({req, " reg11"},  v[31:24], e11[c], m11[c]);
      chk({req, " reg14"},  v[23:16], e14[c], m14[c]);
      chk({req, " reg15"},  v[15:8],  e15[c], m15[c]);
      chk({req, " status"}, v[7:0],   es[c],  ms[c]);
    end
    chk({req, " cmd"}, cmd_reg, e9, m9);
  endtask

  function automatic void m_chan(int c);
    e0[c] = 8'h00; m0[c] = 8'hFF;
    e14[c] = (e14[c] & 8'hC3) | 8'h20; m14[c] = m14[c] | 8'h3C;
    e15[c] = 8'hF8; m15[c] = 8'hFF;
    es[c] = (es[c] & 8'h01) | 8'h06; ms[c] = ms[c] | 8'hFE;
  endfunction

  function automatic void m_full();
    for (int c = 0; c < 2; c++) begin
      m_chan(c);
      e11[c] = 8'h08; m11[c] = 8'hFF;
      e14[c] = (e14[c] & 8'hC0) | 8'h30; m14[c] = m14[c] | 8'h3F;
    end
  endfunction

  function automatic void m_write(bit c, logic [3:0] a, logic [7:0] d);
    case (a)
      4'd0:  begin e0[c] = d;  m0[c] = 8'hFF;  end
      4'd11: begin e11[c] = d; m11[c] = 8'hFF; end
      4'd14: begin e14[c] = d; m14[c] = 8'hFF; end
      4'd15: begin e15[c] = d; m15[c] = 8'hFF; end
      4'd9: begin
        e9 = d; m9 = 8'hFF;
        case (d[7:6])
          2'b11: m_full();
          2'b10: m_chan(0);
          2'b01: m_chan(1);
          default: ;
        endcase
      end
      default: ;
    endcase
  endfunction

  task automatic bus_wr(bit c, logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    ch_sel = c; addr = a; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    m_write(c, a, d);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    addr = 4'd1; rd_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk1("R1 rst_a during hold", rst_a, 1'b1);
    chk1("R6 rst_b during hold", rst_b, 1'b1);
    chk("R3 rd_data blocked", rd_data, 8'h00, 8'hFF);
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
    chk1("R2 acc_en low at 5th edge", acc_en, 1'b0);
    @(negedge clk);
    chk1("R2 acc_en high at 6th edge", acc_en, 1'b1);
    m_full();
    e9 = (e9 & 8'h03) | 8'hC0; m9 = m9 | 8'hFC;
  endtask

  task automatic sw_cmd(logic [7:0] d, logic ea, logic eb, string req);
    bus_wr(1'b0, 4'd9, d);
    chk1({req, " rst_a"}, rst_a, ea);
    chk1({req, " rst_b"}, rst_b, eb);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] picks[6];
    int unsigned seed;
    seed = $urandom(32'd20240);
    for (int c = 0; c < 2; c++) begin
      e0[c] = 0; e11[c] = 0; e14[c] = 0; e15[c] = 0; es[c] = 0;
      m0[c] = 0; m11[c] = 0; m14[c] = 0; m15[c] = 0; ms[c] = 0;
    end
    e9 = 0; m9 = 0;
    repeat (4) @(negedge clk);

    hw_reset();
    check_regs("R6 R9 after hw reset");
    chk("R5 cmd after hw", cmd_reg, 8'hC0, 8'hFC);

    bus_wr(0, 4'd15, 8'h12); bus_wr(0, 4'd14, 8'hFF);
    bus_wr(0, 4'd11, 8'h5A); bus_wr(0, 4'd0, 8'h3C);
    bus_wr(1, 4'd15, 8'h81); bus_wr(1, 4'd14, 8'hE7);
    bus_wr(1, 4'd11, 8'hA5); bus_wr(1, 4'd0, 8'h77);
    check_regs("R4 writes");
    @(negedge clk); addr = 4'd1; ch_sel = 1'b1;
    @(negedge clk); chk("R4 status read", rd_data, 8'h06, 8'hFE);

    bus_wr(0, 4'd5, 8'hAA);
    check_regs("R4 unmapped index");

    @(negedge clk); rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk1("R1 filtered overlap acc_en", acc_en, 1'b1);
    check_regs("R1 filtered overlap");

    sw_cmd(8'h85, 1'b1, 1'b0, "R7 chan A");
    check_regs("R7 R8 chan A reset");
    chk("R5 cmd keeps written", cmd_reg, 8'h85, 8'hFF);
    addr = 4'd9;
    @(negedge clk); chk("R4 cmd read", rd_data, 8'h85, 8'hFF);

    sw_cmd(8'h42, 1'b0, 1'b1, "R7 chan B");
    check_regs("R7 R8 chan B reset");

    sw_cmd(8'hC1, 1'b1, 1'b1, "R6 sw full");
    check_regs("R6 R5 sw full reset");

    bus_wr(0, 4'd15, 8'h3E); bus_wr(1, 4'd14, 8'h5D);
    sw_cmd(8'h2A, 1'b0, 1'b0, "R8 no-action");
    check_regs("R8 no-action regs");

    @(negedge clk);
    addr = 4'd15; ch_sel = 1'b0; din = 8'h55; rd_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk); wr_n = 1'b1;
    repeat (8) @(negedge clk);
    m_full(); e9 = (e9 & 8'h03) | 8'hC0; m9 = m9 | 8'hFC;
    check_regs("R3 write during stretch");

    picks[0] = 4'd0; picks[1] = 4'd9; picks[2] = 4'd11;
    picks[3] = 4'd14; picks[4] = 4'd15; picks[5] = 4'd3;
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] d;
      logic [3:0] a;
      op = $urandom_range(0, 19);
      d = 8'($urandom);
      if (op == 0) begin
        hw_reset();
        check_regs("R6 random hw");
      end else if (op < 3) begin
        d[7:6] = 2'($urandom_range(1, 3));
        bus_wr(1'($urandom), 4'd9, d);
        repeat (6) @(negedge clk);
        check_regs("R7 random cmd");
      end else begin
        a = picks[$urandom_range(0, 5)];
        if (a == 4'd5 || a == 4'd3) a = 4'($urandom_range(2, 8));
        if (a == 4'd9) d[7:6] = 2'b00;
        bus_wr(1'($urandom), a, d);
        check_regs("R4 random write");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule